// File: doc/BRIEF.md
# Prescaled Bus Wait Timeout Timer

This block watches a serial bus transaction for stalls. Software programs a control word, which holds an enable flag and a 15-bit timeout value, and a divider register, which holds the base-2 logarithm of a prescale ratio. While a transaction is active and the timer is enabled, a counter advances once per prescaled tick. A progress strobe from the bus engine reloads that counter. If the counter reaches the programmed value with no progress in between, a sticky timeout flag is raised, and the interrupt logic can mask or route that flag.

The prescaler is a free-running power-of-two divider. Only the tick phase reaches the timeout counter, so changing the divider takes effect at the next rollover and does not restart it. Software can write the control word with the enable bit clear and then write it again with the bit set around a command launch. This restarts the timeout window and leaves the stored value in place.

Top module: `busWaitTimer`

## Requirements
- R1: After reset the timeout flag is 0, the control readback is 0 (enable clear, value 0) and the divider readback is 0.
- R2: A control write stores the enable flag from bit 15 and the timeout value from bits 14:0. The control readback returns that word unchanged from the next cycle on.
- R3: A divider write stores the log2 prescale ratio N. Written values above 14 are stored as 14, and the divider readback shows the stored value.
- R4: The prescaler runs freely from reset release. Counting clock edges after release from 1, a tick occurs on edge j exactly when j mod 2^N equals 0. With N = 0 there is a tick on every clock.
- R5: While the timer is enabled and the transaction is active with no progress, each tick advances the count. The tick that brings the count to the value V is the expiry (V = 0 acts as V = 1). The flag is high after that edge, and the count restarts from zero for a new window.
- R6: A progress strobe sampled high at a clock edge reloads the count to zero at that edge, and no expiry happens on that edge.
- R7: While the transaction-active input is low the count is held at zero and the flag is never set.
- R8: A control write with bit 15 clear stops the timer and zeroes the count but keeps the value field. A later write with bit 15 set starts a full new window.
- R9: The flag stays set until a status clear is sampled. If an expiry and a clear fall on the same edge, the flag stays set.
- R10: The largest value, 0x7FFF, is accepted and expires after exactly 32767 ticks.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| ctrlWrEn | input | 1 | Control word write strobe |
| ctrlWrData | input | 16 | Control word: bit 15 enable, bits 14:0 timeout value |
| divWrEn | input | 1 | Divider write strobe |
| divWrData | input | 4 | Log2 prescale ratio, saturated at 14 |
| txnActive | input | 1 | High while a bus transaction is in progress |
| progress | input | 1 | Bus progress strobe; reloads the count |
| statusClr | input | 1 | Clears the timeout flag |
| ctrlQ | output | 16 | Control word readback |
| divQ | output | 4 | Divider readback |
| timeoutFlag | output | 1 | Sticky timeout status |

## Verification
The bench builds the block with its default parameters: a 15-bit value and a maximum log2 ratio of 14. With a divider of 0 every clock is a tick, so expiry cycles can be predicted exactly. This makes the full 0x7FFF window, the value-0 case, progress reloads and disable/re-enable restarts short enough to run. A run with a divider of 3 checks the free-running tick phase against the number of clock edges since reset. A divider write of 15 checks the saturation at 14.

// File: rtl/bwtPkg.sv
package bwtPkg;

  // strobes from control to datapath
  typedef struct packed {
    logic clrCnt;
    logic incCnt;
    logic setFlag;
    logic clrFlag;
  } bwtStrobes_t;

  // state reported by the datapath to control
  typedef struct packed {
    logic enabled;
    logic tick;
    logic reached;
  } bwtStatus_t;

endpackage

// File: rtl/bwtPrescaler.sv
module bwtPrescaler #(
  parameter int MAX_LOG2 = 14,
  parameter int DIV_W    = 4
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic [DIV_W-1:0] divLog2,
  output logic             tick
);
  localparam int PRE_W = MAX_LOG2;

  logic [PRE_W-1:0] preCnt;
  logic [PRE_W-1:0] mask;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) preCnt <= '0;
    else       preCnt <= preCnt + 1'b1;
  end

  // bit i belongs to the rollover field when i < N
  for (genvar i = 0; i < PRE_W; i++) begin : g_mask
    assign mask[i] = (divLog2 > DIV_W'(i));
  end

  assign tick = &(preCnt | ~mask);

endmodule

// File: rtl/bwtDatapath.sv
module bwtDatapath
  import bwtPkg::*;
#(
  parameter int VALUE_W  = 15,
  parameter int MAX_LOG2 = 14,
  parameter int DIV_W    = 4
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               ctrlWrEn,
  input  logic [VALUE_W:0]   ctrlWrData,
  input  logic               divWrEn,
  input  logic [DIV_W-1:0]   divWrData,
  input  bwtStrobes_t        strobes,
  output bwtStatus_t         status,
  output logic [VALUE_W:0]   ctrlQ,
  output logic [DIV_W-1:0]   divQ,
  output logic               timeoutFlag
);
  localparam logic [DIV_W-1:0]  DIV_MAX = DIV_W'(MAX_LOG2);
  localparam logic [VALUE_W:0]  ONE_EXT = (VALUE_W+1)'(1);

  logic               ctrlEn;
  logic [VALUE_W-1:0] ctrlVal;
  logic [DIV_W-1:0]   divReg;
  logic [VALUE_W-1:0] cnt;
  logic               flagReg;
  logic               tick;
  logic [VALUE_W:0]   cntNext;

  // configuration registers
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      ctrlEn  <= 1'b0;
      ctrlVal <= '0;
    end else if (ctrlWrEn) begin
      ctrlEn  <= ctrlWrData[VALUE_W];
      ctrlVal <= ctrlWrData[VALUE_W-1:0];
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)        divReg <= '0;
    else if (divWrEn) divReg <= (divWrData > DIV_MAX) ? DIV_MAX : divWrData;
  end

  bwtPrescaler #(
    .MAX_LOG2 (MAX_LOG2),
    .DIV_W    (DIV_W)
  ) i_prescaler (
    .clk     (clk),
    .rstN    (rstN),
    .divLog2 (divReg),
    .tick    (tick)
  );

  // tick counter
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)               cnt <= '0;
    else if (strobes.clrCnt) cnt <= '0;
    else if (strobes.incCnt) cnt <= cnt + 1'b1;
  end

  assign cntNext = {1'b0, cnt} + ONE_EXT;

  // sticky flag, set wins over clear
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                flagReg <= 1'b0;
    else if (strobes.setFlag) flagReg <= 1'b1;
    else if (strobes.clrFlag) flagReg <= 1'b0;
  end

  assign status.enabled = ctrlEn;
  assign status.tick    = tick;
  assign status.reached = (cntNext >= {1'b0, ctrlVal});

  assign ctrlQ       = {ctrlEn, ctrlVal};
  assign divQ        = divReg;
  assign timeoutFlag = flagReg;

endmodule

// File: rtl/bwtControl.sv
module bwtControl
  import bwtPkg::*;
(
  input  bwtStatus_t  status,
  input  logic        txnActive,
  input  logic        progress,
  input  logic        statusClr,
  output bwtStrobes_t strobes
);
  logic running;
  logic expire;

  always_comb begin
    running         = status.enabled && txnActive && !progress;
    expire          = running && status.tick && status.reached;
    strobes.clrCnt  = !running || expire;
    strobes.incCnt  = running && status.tick && !expire;
    strobes.setFlag = expire;
    strobes.clrFlag = statusClr;
  end

endmodule

// File: rtl/busWaitTimer.sv
module busWaitTimer
  import bwtPkg::*;
#(
  parameter int VALUE_W  = 15,
  parameter int MAX_LOG2 = 14,
  parameter int DIV_W    = $clog2(MAX_LOG2 + 1)
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               ctrlWrEn,
  input  logic [VALUE_W:0]   ctrlWrData,
  input  logic               divWrEn,
  input  logic [DIV_W-1:0]   divWrData,
  input  logic               txnActive,
  input  logic               progress,
  input  logic               statusClr,
  output logic [VALUE_W:0]   ctrlQ,
  output logic [DIV_W-1:0]   divQ,
  output logic               timeoutFlag
);
  bwtStrobes_t strobes;
  bwtStatus_t  status;

  bwtControl i_control (
    .status    (status),
    .txnActive (txnActive),
    .progress  (progress),
    .statusClr (statusClr),
    .strobes   (strobes)
  );

  bwtDatapath #(
    .VALUE_W  (VALUE_W),
    .MAX_LOG2 (MAX_LOG2),
    .DIV_W    (DIV_W)
  ) i_datapath (
    .clk         (clk),
    .rstN        (rstN),
    .ctrlWrEn    (ctrlWrEn),
    .ctrlWrData  (ctrlWrData),
    .divWrEn     (divWrEn),
    .divWrData   (divWrData),
    .strobes     (strobes),
    .status      (status),
    .ctrlQ       (ctrlQ),
    .divQ        (divQ),
    .timeoutFlag (timeoutFlag)
  );

endmodule

// File: rtl/bwtChecker.sv
module bwtChecker #(
  parameter int VALUE_W  = 15,
  parameter int MAX_LOG2 = 14,
  parameter int DIV_W    = 4
) (
  input logic             clk,
  input logic             rstN,
  input logic             txnActive,
  input logic             progress,
  input logic             statusClr,
  input logic [VALUE_W:0] ctrlQ,
  input logic [DIV_W-1:0] divQ,
  input logic             timeoutFlag
);
  // R3
  div_range_chk: assert property (@(posedge clk) disable iff (!rstN)
    divQ <= DIV_W'(MAX_LOG2));

  // R9
  flag_sticky_chk: assert property (@(posedge clk) disable iff (!rstN)
    (timeoutFlag && !statusClr) |=> timeoutFlag);

  // R7
  idle_no_flag_chk: assert property (@(posedge clk) disable iff (!rstN)
    (!txnActive && !timeoutFlag) |=> !timeoutFlag);

  // R8
  disabled_no_flag_chk: assert property (@(posedge clk) disable iff (!rstN)
    (!ctrlQ[VALUE_W] && !timeoutFlag) |=> !timeoutFlag);

  // R6
  progress_no_flag_chk: assert property (@(posedge clk) disable iff (!rstN)
    (progress && !timeoutFlag) |=> !timeoutFlag);

endmodule

bind busWaitTimer bwtChecker #(
  .VALUE_W  (VALUE_W),
  .MAX_LOG2 (MAX_LOG2),
  .DIV_W    (DIV_W)
) i_bwtChecker (
  .clk         (clk),
  .rstN        (rstN),
  .txnActive   (txnActive),
  .progress    (progress),
  .statusClr   (statusClr),
  .ctrlQ       (ctrlQ),
  .divQ        (divQ),
  .timeoutFlag (timeoutFlag)
);

// File: tb/test_busWaitTimer.sv
module test_busWaitTimer;
  localparam int CLK_PERIOD = 10;
  localparam int VW = 15;
  localparam int DW = 4;

  logic          clk = 1'b0;
  logic          rstN = 1'b0;
  logic          ctrlWrEn = 1'b0;
  logic [VW:0]   ctrlWrData = '0;
  logic          divWrEn = 1'b0;
  logic [DW-1:0] divWrData = '0;
  logic          txnActive = 1'b0;
  logic          progress = 1'b0;
  logic          statusClr = 1'b0;
  logic [VW:0]   ctrlQ;
  logic [DW-1:0] divQ;
  logic          timeoutFlag;

  int checks = 0;
  int errors = 0;
  int cyc = 0;
  int expQ[$];
  string tagQ[$];
  logic prevFlag = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  busWaitTimer i_busWaitTimer (
    .clk (clk), .rstN (rstN),
    .ctrlWrEn (ctrlWrEn), .ctrlWrData (ctrlWrData),
    .divWrEn (divWrEn), .divWrData (divWrData),
    .txnActive (txnActive), .progress (progress), .statusClr (statusClr),
    .ctrlQ (ctrlQ), .divQ (divQ), .timeoutFlag (timeoutFlag)
  );

  // clock edges since reset release
  always @(posedge clk) if (rstN) cyc <= cyc + 1;

  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // monitor: every rising edge of the flag must match a queued expectation
  always @(negedge clk) begin
    if (rstN) begin
      if (timeoutFlag && !prevFlag) begin
        checks++;
        if (expQ.size() == 0) begin
          errors++;
          $display("FAIL unexpected timeout actual=%0d expected=none", cyc);
        end else begin
          int e;
          string t;
          e = expQ.pop_front();
          t = tagQ.pop_front();
          if (e != cyc) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", t, cyc, e);
          end
        end
      end
      prevFlag <= timeoutFlag;
    end
  end

  task automatic expectAt(input int e, input string t);
    expQ.push_back(e);
    tagQ.push_back(t);
  endtask

  task automatic waitUntil(input int e);
    while (cyc < e) @(negedge clk);
  endtask

  task automatic writeCtrl(input logic en, input int val);
    ctrlWrData = {en, VW'(val)};
    ctrlWrEn = 1'b1;
    @(posedge clk); @(negedge clk);
    ctrlWrEn = 1'b0;
  endtask

  task automatic writeDiv(input int val);
    divWrData = DW'(val);
    divWrEn = 1'b1;
    @(posedge clk); @(negedge clk);
    divWrEn = 1'b0;
  endtask

  task automatic endTxn(input string req);
    txnActive = 1'b0;
    statusClr = 1'b1;
    @(posedge clk); @(negedge clk);
    statusClr = 1'b0;
    check(req, int'(timeoutFlag), 0);
  endtask

  function automatic int nextMult(input int from, input int p);
    return ((from + p - 1) / p) * p;
  endfunction

  initial begin
    repeat (190000) @(posedge clk);
    errors++; checks++;
    $display("FAIL watchdog actual=expired expected=done");
    $display("  Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    int c;
    repeat (3) @(negedge clk);
    // R1
    check("R1 flag", int'(timeoutFlag), 0);
    check("R1 ctrl", int'(ctrlQ), 0);
    check("R1 div", int'(divQ), 0);
    rstN = 1'b1;
    @(negedge clk);

    // R2 readback
    writeCtrl(1'b1, 7);
    check("R2 ctrl readback", int'(ctrlQ), 32768 + 7);

    // R3 saturation
    writeDiv(15);
    check("R3 div clamp", int'(divQ), 14);
    writeDiv(0);
    check("R3 div zero", int'(divQ), 0);

    // R5 basic expiry, N=0, V=7
    c = cyc; txnActive = 1'b1;
    expectAt(c + 7, "R5 basic");
    waitUntil(c + 7);
    endTxn("R9 clear basic");

    // R5 value 0 acts as 1
    writeCtrl(1'b1, 0);
    c = cyc; txnActive = 1'b1;
    expectAt(c + 1, "R5 value0");
    waitUntil(c + 1);
    endTxn("R9 clear value0");

    // R5 restart after expiry, R9 clear mid-transaction
    writeCtrl(1'b1, 4);
    c = cyc; txnActive = 1'b1;
    expectAt(c + 4, "R5 first window");
    expectAt(c + 8, "R5 restarted window");
    waitUntil(c + 4);
    statusClr = 1'b1;
    @(posedge clk); @(negedge clk);
    statusClr = 1'b0;
    check("R9 clear", int'(timeoutFlag), 0);
    waitUntil(c + 8);
    endTxn("R9 clear restart");

    // R9 set beats clear on the same edge
    writeCtrl(1'b1, 5);
    c = cyc; txnActive = 1'b1;
    expectAt(c + 5, "R9 setup expiry");
    waitUntil(c + 9);
    statusClr = 1'b1;
    @(posedge clk); @(negedge clk);
    statusClr = 1'b0;
    check("R9 set over clear", int'(timeoutFlag), 1);
    endTxn("R9 clear after collision");

    // R6 progress reload
    writeCtrl(1'b1, 10);
    c = cyc; txnActive = 1'b1;
    expectAt(c + 17, "R6 progress reload");
    waitUntil(c + 6);
    progress = 1'b1;
    @(posedge clk); @(negedge clk);
    progress = 1'b0;
    waitUntil(c + 17);
    endTxn("R9 clear progress");

    // R8 disable / re-enable restarts window, keeps value
    writeCtrl(1'b1, 20);
    c = cyc; txnActive = 1'b1;
    expectAt(c + 37, "R8 restart after re-enable");
    waitUntil(c + 15);
    writeCtrl(1'b0, 20);
    check("R8 value kept", int'(ctrlQ), 20);
    writeCtrl(1'b1, 20);
    waitUntil(c + 37);
    endTxn("R9 clear reenable");

    // R7 inactive transaction never times out
    writeCtrl(1'b1, 3);
    repeat (20) @(negedge clk);
    check("R7 idle no flag", int'(timeoutFlag), 0);

    // R8 disabled timer never times out
    writeCtrl(1'b0, 3);
    txnActive = 1'b1;
    repeat (20) @(negedge clk);
    check("R8 disabled no flag", int'(timeoutFlag), 0);
    txnActive = 1'b0;
    @(negedge clk);

    // R4 prescaled ticks, N=3, V=5
    writeDiv(3);
    writeCtrl(1'b1, 5);
    c = cyc; txnActive = 1'b1;
    expectAt(nextMult(c + 1, 8) + 4 * 8, "R4 prescaled expiry");
    waitUntil(nextMult(c + 1, 8) + 4 * 8);
    endTxn("R9 clear prescaled");
    writeDiv(0);

    // R10 maximum value
    writeCtrl(1'b1, 32767);
    check("R10 max readback", int'(ctrlQ), 65535);
    c = cyc; txnActive = 1'b1;
    expectAt(c + 32767, "R10 max window");
    waitUntil(c + 32767);
    endTxn("R9 clear max");

    repeat (3) @(negedge clk);
    check("R5 all expiries seen", expQ.size(), 0);
    $display("  Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule